// File: doc/BRIEF.md
# Posted-Write Pending Tracker

This block is the bus-side register front end of a peripheral whose working registers live in a slower, unrelated clock domain. Writes to the ten synchronized registers are posted: the bus sees the write accepted in the same cycle, and the value then crosses to the slow domain through a toggle handshake. A read-only pending register shows, one bit per synchronized register, which of those crossings are still in flight.

A small set of local registers is written at once and has no pending bit: identification, configuration, two interrupt-routing words, the interface control word, the pending word and the reset-status word. Posted mode is on after reset. When it is turned off, an access to a synchronized register holds the bus ready low until the crossing has finished. In posted mode, touching a register whose crossing is not finished is an error: a read returns an error response and a write is dropped. Both raise a sticky error flag. A soft reset is requested through the interface control word. It clears the local state and, via its own handshake, the slow-domain registers. A status bit reports when that reset is complete.

The slow-domain register values are brought out as a flat sink bus for the functional logic, which lies outside this block.

Top module: `wpend_regfront`

## Requirements
- R1: After hard reset: the ID word (word address 0) reads ID_VALUE, the interface control word (address 5) reads 0x4, the pending word (address 6) reads 0, reset status (address 2) bit 0 reads 1, and the sticky error flag is 0.
- R2: The local registers CFG (address 1), IRQ_EN (address 3) and WAKE_EN (address 4) accept a write in the same cycle, read back the written value, and never set a pending bit.
- R3: Synchronized registers occupy word addresses 8 to 17. Slot k = address minus 8, and pending bit k belongs to slot k. The slots are, in order: control, counter, load, trigger, match, positive tick, negative tick, tick count, interrupt mask set, interrupt mask count. In posted mode a write to an idle slot completes without a stall, with no error response, and its pending bit reads 1 from the next cycle.
- R4: A pending bit returns to 0 on its own after the slow-domain update. By then the slot's sink output holds the written value, and a bus read of the slot returns it.
- R5: In posted mode, a read of a slot whose bit is pending completes without a stall, with an error response and read data 0, and it sets the sticky error flag.
- R6: In posted mode, a write to a slot whose bit is pending is dropped. It gets an error response and sets the sticky error flag, and the slot keeps the earlier value.
- R7: With interface control bit 2 (posted) cleared, a write to a synchronized slot stalls ready until the update is complete. When it finishes, the pending bit is 0 and the sink already holds the value.
- R8: With posted mode off, a read of a pending slot stalls without an error and then returns the slot's value.
- R9: Writing the interface control word with bit 1 set (for example 0x06) starts a soft reset. Reset status bit 0 reads 0 from the next cycle and returns to 1 once the slow domain is cleared. CFG, IRQ_EN and WAKE_EN become 0, posted mode becomes 1, and all slots and sinks become 0.
- R10: The sticky error flag stays at 1 until a hard or soft reset.
- R11: Word addresses 7 and 18 to 31 read 0, give no error, and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus-domain reset, active low |
| slow_clk_i | input | 1 | Functional (slow) clock |
| slow_rst_ni | input | 1 | Slow-domain reset, active low |
| bus_req_i | input | 1 | Access request, held until ready |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_ready_o | output | 1 | Access completes this cycle |
| bus_rdata_o | output | DATA_W | Read data, valid with ready |
| bus_resp_err_o | output | 1 | Error response, valid with ready |
| err_sticky_o | output | 1 | Sticky access-error flag |
| slow_regs_o | output | NUM_SYNC*DATA_W | Slow-domain register values, slot k at bits k*DATA_W |

## Verification
The bench builds the block with DATA_W = 16, NUM_SYNC = 10 and ADDR_W = 5. With these values all ten slots can be swept one after another. The pending word can be compared against a single computed one-hot mask for each slot, and the whole 32-word address space, unmapped holes included, is within reach. The slow clock runs at an unrelated period of 23 ns. Several bus cycles therefore pass before any crossing finishes, which lets the bench reliably land a second access inside the pending window to exercise the error, drop and stall paths.

// File: rtl/wpend_pkg.sv
package wpend_pkg;
  localparam int unsigned A_ID      = 0;
  localparam int unsigned A_CFG     = 1;
  localparam int unsigned A_SYSSTAT = 2;
  localparam int unsigned A_IRQEN   = 3;
  localparam int unsigned A_WAKEEN  = 4;
  localparam int unsigned A_IFCTRL  = 5;
  localparam int unsigned A_PEND    = 6;
  localparam int unsigned SYNC_BASE = 8;

  localparam int IF_SRST_BIT   = 1;
  localparam int IF_POSTED_BIT = 2;

  function automatic logic addr_is_sync(int unsigned a, int unsigned n);
    return (a >= SYNC_BASE) && (a < SYNC_BASE + n);
  endfunction

  function automatic int unsigned sync_slot(int unsigned a);
    return a - SYNC_BASE;
  endfunction
endpackage

// File: rtl/wpend_sync2.sv
module wpend_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/wpend_xfer.sv
module wpend_xfer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_clk_i,
  input  logic slow_rst_ni,
  input  logic launch_i,
  output logic pending_o,
  output logic apply_o
);
  logic req_tgl_q, ack_s, req_s, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_tgl_q <= 1'b0;
    else if (launch_i) req_tgl_q <= ~req_tgl_q;
  end

  wpend_sync2 u_req_sync (
    .clk_i(slow_clk_i), .rst_ni(slow_rst_ni), .d_i(req_tgl_q), .q_o(req_s)
  );

  always_ff @(posedge slow_clk_i or negedge slow_rst_ni) begin
    if (!slow_rst_ni) seen_q <= 1'b0;
    else seen_q <= req_s;
  end

  assign apply_o = req_s ^ seen_q;

  wpend_sync2 u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(seen_q), .q_o(ack_s)
  );

  assign pending_o = req_tgl_q ^ ack_s;

  AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !pending_o);  // R6
  AST_PEND_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> pending_o);  // R3
  AST_APPLY_PULSE: assert property (@(posedge slow_clk_i) disable iff (!slow_rst_ni)
    apply_o |=> !apply_o);  // R4
endmodule

// File: rtl/wpend_chan.sv
module wpend_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_clk_i,
  input  logic              slow_rst_ni,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bus_clr_i,
  input  logic              slow_clr_i,
  output logic              pending_o,
  output logic [DATA_W-1:0] hold_o,
  output logic [DATA_W-1:0] sink_o
);
  logic [DATA_W-1:0] hold_q, sink_q;
  logic apply;

  wpend_xfer u_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_clk_i(slow_clk_i),
    .slow_rst_ni(slow_rst_ni), .launch_i(launch_i),
    .pending_o(pending_o), .apply_o(apply)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (bus_clr_i) hold_q <= '0;
    else if (launch_i) hold_q <= wdata_i;
  end

  always_ff @(posedge slow_clk_i or negedge slow_rst_ni) begin
    if (!slow_rst_ni) sink_q <= '0;
    else if (slow_clr_i) sink_q <= '0;
    else if (apply) sink_q <= hold_q;
  end

  assign hold_o = hold_q;
  assign sink_o = sink_q;

  AST_SINK_TAKES_HOLD: assert property (@(posedge slow_clk_i) disable iff (!slow_rst_ni)
    (apply && !slow_clr_i) |=> (sink_q == $past(hold_q)));  // R4
endmodule

// File: rtl/wpend_regfront.sv
module wpend_regfront
  import wpend_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          NUM_SYNC = 10,
  parameter int          ADDR_W   = 5,
  parameter logic [31:0] ID_VALUE = 32'h0000_0A51
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       slow_clk_i,
  input  logic                       slow_rst_ni,
  input  logic                       bus_req_i,
  input  logic                       bus_we_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic                       bus_ready_o,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic                       bus_resp_err_o,
  output logic                       err_sticky_o,
  output logic [NUM_SYNC*DATA_W-1:0] slow_regs_o
);
  localparam int IDX_W = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1;

  logic [DATA_W-1:0] cfg_q, irqen_q, wakeen_q;
  logic              posted_q, err_q, wait_q;
  logic [IDX_W-1:0]  wait_idx_q;

  logic [NUM_SYNC-1:0] pend, launch;
  logic [DATA_W-1:0]   hold [NUM_SYNC];
  logic                srst_pend, slow_clr, sys_done;

  int unsigned       addr_u;
  logic              sync_hit, pend_hit, launch_any;
  logic [IDX_W-1:0]  idx;

  // named events for the assertions
  logic lost_wr, bad_rd, srst_go, imm_wr, nxt_wait;

  assign addr_u     = 32'(bus_addr_i);
  assign sync_hit   = addr_is_sync(addr_u, NUM_SYNC);
  assign idx        = IDX_W'(sync_slot(addr_u));
  assign pend_hit   = sync_hit && pend[idx];
  assign launch_any = |launch;
  assign sys_done   = !srst_pend;
  assign imm_wr     = !wait_q && bus_req_i && bus_we_i && !sync_hit;
  assign srst_go    = imm_wr && (addr_u == A_IFCTRL) &&
                      bus_wdata_i[IF_SRST_BIT] && !srst_pend;

  always_comb begin
    bus_ready_o    = 1'b1;
    bus_resp_err_o = 1'b0;
    bus_rdata_o    = '0;
    launch         = '0;
    lost_wr        = 1'b0;
    bad_rd         = 1'b0;
    nxt_wait       = wait_q;
    if (wait_q) begin
      bus_ready_o = !pend[wait_idx_q];
      if (bus_ready_o) nxt_wait = 1'b0;
    end else if (bus_req_i) begin
      if (sync_hit) begin
        if (pend_hit) begin
          if (posted_q) begin
            bus_resp_err_o = 1'b1;
            if (bus_we_i) lost_wr = 1'b1;
            else bad_rd = 1'b1;
          end else begin
            bus_ready_o = 1'b0;
          end
        end else if (bus_we_i) begin
          launch[idx] = 1'b1;
          if (!posted_q) begin
            bus_ready_o = 1'b0;
            nxt_wait    = 1'b1;
          end
        end else begin
          bus_rdata_o = hold[idx];
        end
      end else if (!bus_we_i) begin
        case (addr_u)
          A_ID:      bus_rdata_o = DATA_W'(ID_VALUE);
          A_CFG:     bus_rdata_o = cfg_q;
          A_SYSSTAT: bus_rdata_o = DATA_W'(sys_done);
          A_IRQEN:   bus_rdata_o = irqen_q;
          A_WAKEEN:  bus_rdata_o = wakeen_q;
          A_IFCTRL:  bus_rdata_o[IF_POSTED_BIT] = posted_q;
          A_PEND:    bus_rdata_o = DATA_W'(pend);
          default:   bus_rdata_o = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      irqen_q    <= '0;
      wakeen_q   <= '0;
      posted_q   <= 1'b1;
      err_q      <= 1'b0;
      wait_q     <= 1'b0;
      wait_idx_q <= '0;
    end else begin
      wait_q <= nxt_wait;
      if (launch_any && !posted_q) wait_idx_q <= idx;
      if (srst_go) begin
        cfg_q    <= '0;
        irqen_q  <= '0;
        wakeen_q <= '0;
        posted_q <= 1'b1;
        err_q    <= 1'b0;
      end else begin
        if (lost_wr || bad_rd) err_q <= 1'b1;
        if (imm_wr) begin
          case (addr_u)
            A_CFG:    cfg_q    <= bus_wdata_i;
            A_IRQEN:  irqen_q  <= bus_wdata_i;
            A_WAKEEN: wakeen_q <= bus_wdata_i;
            A_IFCTRL: posted_q <= bus_wdata_i[IF_POSTED_BIT];
            default:  ;
          endcase
        end
      end
    end
  end

  assign err_sticky_o = err_q;

  wpend_xfer u_srst (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_clk_i(slow_clk_i),
    .slow_rst_ni(slow_rst_ni), .launch_i(srst_go),
    .pending_o(srst_pend), .apply_o(slow_clr)
  );

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_chan
    wpend_chan #(.DATA_W(DATA_W)) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .slow_clk_i(slow_clk_i),
      .slow_rst_ni(slow_rst_ni), .launch_i(launch[g]), .wdata_i(bus_wdata_i),
      .bus_clr_i(srst_go), .slow_clr_i(slow_clr), .pending_o(pend[g]),
      .hold_o(hold[g]), .sink_o(slow_regs_o[g*DATA_W +: DATA_W])
    );
  end

  AST_POSTED_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (posted_q && !wait_q && bus_req_i) |-> bus_ready_o);  // R3
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !srst_go) |=> err_q);  // R10
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_sticky_o) |-> $past(bus_resp_err_o));  // R5
  AST_NONPOSTED_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_any && !posted_q) |=> !bus_ready_o);  // R7
  AST_SRST_DONE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_go |=> !sys_done);  // R9
endmodule

// File: tb/wpend_regfront_bench.sv
`timescale 1ns/1ps
module wpend_regfront_bench;
  localparam int DW = 16;
  localparam int NS = 10;
  localparam int AW = 5;
  localparam logic [31:0] IDV = 32'h0000_0A51;

  logic clk = 1'b0, sclk = 1'b0;
  logic rst_n = 1'b0, srst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, resp_err, err_st;
  logic [DW-1:0] rdata;
  logic [NS*DW-1:0] sinks;

  int nchecks = 0, nerrors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always #11.5 sclk = ~sclk;

  wpend_regfront #(.DATA_W(DW), .NUM_SYNC(NS), .ADDR_W(AW), .ID_VALUE(IDV)) u_wpend_regfront (
    .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(sclk), .slow_rst_ni(srst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_ready_o(ready), .bus_rdata_o(rdata), .bus_resp_err_o(resp_err),
    .err_sticky_o(err_st), .slow_regs_o(sinks)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic acc(input logic w, input int unsigned a, input logic [DW-1:0] wd,
                     output logic [DW-1:0] rd, output logic re, output int stalls);
    @(negedge clk);
    req = 1'b1; we = w; addr = a[AW-1:0]; wdata = wd; stalls = 0;
    #1;
    while (!ready && stalls < 5000) begin
      @(negedge clk); #1; stalls++;
    end
    rd = rdata; re = resp_err;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input int unsigned a, input logic [DW-1:0] wd, output logic re, output int st);
    logic [DW-1:0] d;
    acc(1'b1, a, wd, d, re, st);
  endtask

  task automatic rd(input int unsigned a, output logic [DW-1:0] d, output logic re, output int st);
    acc(1'b0, a, '0, d, re, st);
  endtask

  task automatic wait_clear(input string rq, input int unsigned pend_addr, input logic [DW-1:0] mask);
    logic [DW-1:0] d; logic re; int st; int n;
    n = 0;
    d = mask;
    while (((d & mask) != 0) && n < 300) begin
      rd(pend_addr, d, re, st);
      n++;
    end
    check(rq, 32'((d & mask) == 0), 32'd1);
  endtask

  logic [DW-1:0] d;
  logic re;
  int st;

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nerrors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge sclk);
    @(negedge clk);
    rst_n = 1'b1; srst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 reset state
    check("R1 err flag", 32'(err_st), 0);
    rd(0, d, re, st); check("R1 id", 32'(d), IDV & 32'hFFFF);
    rd(5, d, re, st); check("R1 ifctrl", 32'(d), 32'h4);
    rd(6, d, re, st); check("R1 pending", 32'(d), 0);
    rd(2, d, re, st); check("R1 sysstat", 32'(d), 1);

    // R2 immediate registers
    wr(1, 16'h1234, re, st); check("R2 cfg stall", 32'(st), 0);
    wr(3, 16'h00F0, re, st);
    wr(4, 16'h0F0F, re, st);
    rd(6, d, re, st); check("R2 no pending", 32'(d), 0);
    rd(1, d, re, st); check("R2 cfg", 32'(d), 32'h1234);
    rd(3, d, re, st); check("R2 irqen", 32'(d), 32'h00F0);
    rd(4, d, re, st); check("R2 wakeen", 32'(d), 32'h0F0F);

    // R11 unmapped words
    for (int a = 18; a < 32; a++) begin
      wr(a, 16'hFFFF, re, st);
      rd(a, d, re, st); check("R11 unmapped read", 32'({re, d}), 0);
    end
    wr(7, 16'hFFFF, re, st);
    rd(7, d, re, st); check("R11 word 7", 32'({re, d}), 0);
    rd(6, d, re, st); check("R11 no pending", 32'(d), 0);

    // R3/R4 posted sweep over every slot
    for (int i = 0; i < NS; i++) begin
      logic [DW-1:0] v;
      v = DW'(16'h1000 + i * 16'h0213 + 1);
      wr(8 + i, v, re, st);
      check("R3 posted no stall", 32'(st), 0);
      check("R3 no error", 32'(re), 0);
      rd(6, d, re, st); check("R3 pending one-hot", 32'(d), 32'(1) << i);
      wait_clear("R4 pending clears", 6, DW'(1) << i);
      check("R4 sink value", 32'(sinks[i*DW +: DW]), 32'(v));
      rd(8 + i, d, re, st); check("R4 readback", 32'(d), 32'(v));
    end

    // R5 posted read while pending
    wr(12, 16'hA5A5, re, st);
    rd(12, d, re, st);
    check("R5 error response", 32'(re), 1);
    check("R5 read data zero", 32'(d), 0);
    check("R5 sticky set", 32'(err_st), 1);
    wait_clear("R5 clear", 6, DW'(1) << 4);
    check("R10 still sticky", 32'(err_st), 1);
    rd(12, d, re, st); check("R5 later value", 32'(d), 32'hA5A5);

    // R6 posted write to pending slot is dropped
    wr(10, 16'hBEEF, re, st); check("R6 first ok", 32'(re), 0);
    wr(10, 16'hC0DE, re, st); check("R6 drop error", 32'(re), 1);
    wait_clear("R6 clear", 6, DW'(1) << 2);
    check("R6 sink keeps first", 32'(sinks[2*DW +: DW]), 32'hBEEF);
    rd(10, d, re, st); check("R6 readback first", 32'(d), 32'hBEEF);
    check("R10 sticky after drop", 32'(err_st), 1);

    // R7 non-posted write stalls
    wr(5, 16'h0000, re, st);
    rd(5, d, re, st); check("R7 posted off", 32'(d), 0);
    wr(15, 16'h7777, re, st);
    check("R7 stalled", 32'(st > 0), 1);
    check("R7 no error", 32'(re), 0);
    check("R7 sink ready", 32'(sinks[7*DW +: DW]), 32'h7777);
    rd(6, d, re, st); check("R7 pending zero", 32'(d), 0);

    // R8 non-posted read of a pending slot stalls
    wr(5, 16'h0004, re, st);
    wr(16, 16'h4242, re, st);
    wr(5, 16'h0000, re, st);
    rd(16, d, re, st);
    check("R8 stalled", 32'(st > 0), 1);
    check("R8 no error", 32'(re), 0);
    check("R8 value", 32'(d), 32'h4242);

    // R9 soft reset
    wr(5, 16'h0006, re, st);
    rd(2, d, re, st); check("R9 not done", 32'(d), 0);
    wait_clear("R9 done returns", 2, 16'h0);
    begin
      int n = 0;
      d = 0;
      while (d[0] == 1'b0 && n < 300) begin rd(2, d, re, st); n++; end
      check("R9 sysstat done", 32'(d), 1);
    end
    rd(1, d, re, st); check("R9 cfg cleared", 32'(d), 0);
    rd(3, d, re, st); check("R9 irqen cleared", 32'(d), 0);
    rd(5, d, re, st); check("R9 posted restored", 32'(d), 32'h4);
    check("R10 cleared by soft reset", 32'(err_st), 0);
    check("R9 sinks cleared", 32'(sinks == '0), 1);
    rd(8, d, re, st); check("R9 slot cleared", 32'(d), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule